// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block drives one pulse-width-modulated pin for a display backlight from a reference clock. The period is built from two nested counters. A prescale counter divides the reference clock, and each time it wraps a step counter advances. After the final step, one extra reference clock restarts both counters. The period is therefore `prescale * scale + 1` reference clocks. The output is active for the first `duty` steps and inactive for the rest of the period.

Software configures the block through a byte-wide register port. The block holds a control byte with invert and enable bits, an 8-bit prescale byte, and two 16-bit values, scale and duty. Each 16-bit value is split over two consecutive addresses, with the low byte first. Writes take effect in the cycle after the write edge and are not buffered, so one period can mix old and new settings. A separate mux select hands the pin to the PWM function. Without it the pin is released as an undriven input.

The sequencer has three named states. ST_IDLE holds both counters at zero with the output inactive. ST_RUN counts prescale clocks and scale steps. ST_WRAP is the single restart clock. The transitions are:

- idle-to-run, taken when enable is set and prescale and scale are both nonzero.
- run-to-wrap, taken on the last prescale clock of the last step.
- wrap-to-run, always taken after one clock.
- any-to-idle, taken whenever enable is cleared or prescale or scale is zero.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset every register reads 0x00, `pwm_oe` is 0 and `pwm_out` is 0.
- R2: Registers read back the last value written. The map relative to `BASE_ADDR` is:
  - +0: control (bit 0 invert, bit 1 enable).
  - +1: prescale.
  - +2 and +3: scale, low byte then high byte.
  - +4 and +5: duty, low byte then high byte.

  Any other address reads 0x00.
- R3: While `mux_pwm` is 0, `pwm_oe` is 0 and `pwm_out` is 0. While it is 1, `pwm_oe` is 1.
- R4: When enabled with nonzero prescale P and scale S, the output pattern repeats every P*S+1 clocks. The first period starts in the second cycle after the edge that writes the enable bit.
- R5: When duty D is at most S, the output is active for the first P*D clocks of each period and inactive for the remaining clocks.
- R6: When D is greater than S, the output is active for every clock of the period, including the restart clock.
- R7: When D is 0, the output stays inactive.
- R8: When P or S is 0, the sequencer stays in ST_IDLE and the output stays inactive.
- R9: The invert bit flips the pin level. The inactive level is therefore high when invert is set, and this also holds while the block is disabled.
- R10: Clearing enable makes the output inactive in the cycle after the write edge and resets both counters. Setting enable again restarts from the beginning of a period.
- R11: A duty write made while running changes the output in the cycle after the write edge, without waiting for the period to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for `reg_addr` (combinational) |
| mux_pwm | input | 1 | 1 selects the PWM function on the pin |
| pwm_out | output | 1 | Pin output level |
| pwm_oe | output | 1 | Pin output enable; 0 leaves the pin undriven |

## Verification
The bench aims at the edges of the duty comparison:

- duty equal to scale, where a design that treats the restart clock as a step would stretch the high time by one clock;
- duty above scale, where an off-by-one would drop the restart clock to low;
- zero prescale or zero scale, where a naive counter would underflow and free-run.

It also interrupts a period part-way with a disable and re-enable. A design that kept its counters across the disable would resume mid-period instead of restarting. A duty write made while running must show on the pin in the very next cycle. A design that latched settings at the period boundary would fail that check. Inverted polarity is checked while disabled as well, since the idle level must follow the invert bit.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
    localparam int PRE_W = 8;
    localparam int SCL_W = 16;
    localparam int SCL_BYTES = SCL_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WRAP = 2'd2
    } bl_state_e;

    typedef struct packed {
        logic             en;
        logic             inv;
        logic [PRE_W-1:0] pre;
        logic [SCL_W-1:0] scale;
        logic [SCL_W-1:0] duty;
    } bl_cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output bl_cfg_t           cfg
);
    localparam int OFF_CTRL  = 0;
    localparam int OFF_PRE   = 1;
    localparam int OFF_SCALE = 2;
    localparam int OFF_DUTY  = OFF_SCALE + SCL_BYTES;

    logic [ADDR_W-1:0] off;
    logic              in_rng;
    logic              en_q, inv_q;
    logic [PRE_W-1:0]  pre_q;
    logic [SCL_W-1:0]  scale_w, duty_w;

    assign off    = addr - BASE_ADDR;
    assign in_rng = (addr >= BASE_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            inv_q <= 1'b0;
            pre_q <= '0;
        end else if (wr_en && in_rng) begin
            if (off == ADDR_W'(OFF_CTRL)) begin
                inv_q <= wdata[0];
                en_q  <= wdata[1];
            end
            if (off == ADDR_W'(OFF_PRE)) pre_q <= wdata[PRE_W-1:0];
        end
    end

    for (genvar b = 0; b < SCL_BYTES; b++) begin : g_lane
        logic [7:0] scl_byte, dty_byte;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scl_byte <= 8'h00;
                dty_byte <= 8'h00;
            end else if (wr_en && in_rng) begin
                if (off == ADDR_W'(OFF_SCALE + b)) scl_byte <= wdata;
                if (off == ADDR_W'(OFF_DUTY + b))  dty_byte <= wdata;
            end
        end
        assign scale_w[8*b +: 8] = scl_byte;
        assign duty_w[8*b +: 8]  = dty_byte;
    end

    always_comb begin
        rdata = 8'h00;
        if (in_rng) begin
            if (off == ADDR_W'(OFF_CTRL)) rdata = {6'b0, en_q, inv_q};
            if (off == ADDR_W'(OFF_PRE))  rdata = pre_q;
            for (int b = 0; b < SCL_BYTES; b++) begin
                if (off == ADDR_W'(OFF_SCALE + b)) rdata = scale_w[8*b +: 8];
                if (off == ADDR_W'(OFF_DUTY + b))  rdata = duty_w[8*b +: 8];
            end
        end
    end

    assign cfg = '{en: en_q, inv: inv_q, pre: pre_q, scale: scale_w, duty: duty_w};
endmodule

// File: rtl/bl_pwm_seq.sv
module bl_pwm_seq
    import bl_pwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bl_cfg_t cfg,
    output logic    level
);
    bl_state_e        state, nxt;
    logic [PRE_W-1:0] pre_cnt;
    logic [SCL_W-1:0] step_cnt;
    logic             run_ok, pre_last, step_last;

    assign run_ok    = cfg.en && (cfg.pre != '0) && (cfg.scale != '0);
    assign pre_last  = pre_cnt >= (cfg.pre - PRE_W'(1));
    assign step_last = step_cnt >= (cfg.scale - SCL_W'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (run_ok) nxt = ST_RUN;
            ST_RUN: begin
                if (!run_ok)                    nxt = ST_IDLE;
                else if (pre_last && step_last) nxt = ST_WRAP;
            end
            ST_WRAP: nxt = run_ok ? ST_RUN : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pre_cnt  <= '0;
            step_cnt <= '0;
        end else begin
            state <= nxt;
            if (!run_ok || state != ST_RUN) begin
                pre_cnt  <= '0;
                step_cnt <= '0;
            end else if (pre_last) begin
                pre_cnt  <= '0;
                step_cnt <= step_last ? '0 : step_cnt + SCL_W'(1);
            end else begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end
        end
    end

    always_comb begin
        level = 1'b0;
        if (run_ok) begin
            unique case (state)
                ST_RUN:  level = (step_cnt < cfg.duty);
                ST_WRAP: level = (cfg.duty > cfg.scale);
                default: level = 1'b0;
            endcase
        end
    end

    // R8
    zero_cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.pre == '0 || cfg.scale == '0) |=> (state == ST_IDLE));

    // R10
    disable_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (state == ST_IDLE && pre_cnt == '0 && step_cnt == '0));

    // R4
    wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRAP) |=> (state != ST_WRAP && pre_cnt == '0 && step_cnt == '0));

    // R6
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && state != ST_IDLE && cfg.duty > cfg.scale) |-> level);
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
    import bl_pwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              mux_pwm,
    output logic              pwm_out,
    output logic              pwm_oe
);
    bl_cfg_t cfg;
    logic    level;

    bl_pwm_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
    );

    bl_pwm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .level(level)
    );

    assign pwm_oe  = mux_pwm;
    assign pwm_out = mux_pwm ? (level ^ cfg.inv) : 1'b0;

    // R3
    pin_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_pwm |-> (!pwm_oe && !pwm_out));
endmodule

// File: tb/bl_pwm_top_tb.sv
module bl_pwm_top_tb;
    localparam logic [7:0] BASE = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       mux_pwm = 1'b0;
    logic       pwm_out, pwm_oe;

    int    n_run = 0;
    int    n_fail = 0;
    logic  exp_q[$];
    string cur_req = "R4";

    always #10 clk = ~clk;

    bl_pwm_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mux_pwm(mux_pwm),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: pops one expected level per cycle, a quarter period after the edge
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            logic e;
            e = exp_q.pop_front();
            check(cur_req, int'(pwm_out), int'(e));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, int'(reg_rdata), int'(exp));
    endtask

    task automatic setup(input int p, input int s, input int d, input bit inv);
        wr(BASE, {6'b0, 1'b0, inv});
        wr(BASE + 8'd1, 8'(p));
        wr(BASE + 8'd2, 8'(s)); wr(BASE + 8'd3, 8'(s >> 8));
        wr(BASE + 8'd4, 8'(d)); wr(BASE + 8'd5, 8'(d >> 8));
    endtask

    // driver: expected levels for n periods (or n clocks when cfg is zero)
    task automatic push(input int p, input int s, input int d, input bit inv, input int n, input int limit);
        int cnt = 0;
        if (p == 0 || s == 0) begin
            for (int i = 0; i < n; i++) exp_q.push_back(inv);
        end else begin
            for (int k = 0; k < n; k++)
                for (int c = 0; c <= p * s; c++) begin
                    logic act;
                    act = (c < p * s) ? ((c / p) < d) : (d > s);
                    if (limit == 0 || cnt < limit) exp_q.push_back(act ^ inv);
                    cnt++;
                end
        end
    endtask

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic run_cfg(input string req, input int p, input int s, input int d, input bit inv);
        setup(p, s, d, inv);
        wr(BASE, {6'b0, 1'b1, inv});
        cur_req = req;
        push(p, s, d, inv, 2, 0);
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 6; a++) rd_chk("R1", BASE + 8'(a), 8'h00);
        check("R1", int'(pwm_oe), 0);
        check("R1", int'(pwm_out), 0);

        // R2 readback and unmapped read
        setup(3, 16'h1234, 16'hA5C3, 1'b1);
        rd_chk("R2", BASE, 8'h01);
        rd_chk("R2", BASE + 8'd1, 8'h03);
        rd_chk("R2", BASE + 8'd2, 8'h34);
        rd_chk("R2", BASE + 8'd3, 8'h12);
        rd_chk("R2", BASE + 8'd4, 8'hC3);
        rd_chk("R2", BASE + 8'd5, 8'hA5);
        rd_chk("R2", BASE + 8'd6, 8'h00);
        rd_chk("R2", BASE - 8'd1, 8'h00);

        // R3 pin released while enabled but not muxed
        setup(1, 2, 3, 1'b1);
        wr(BASE, 8'h03);
        repeat (4) begin
            @(negedge clk);
            check("R3", int'(pwm_oe), 0);
            check("R3", int'(pwm_out), 0);
        end
        wr(BASE, 8'h00);
        mux_pwm = 1'b1;
        @(negedge clk);
        check("R3", int'(pwm_oe), 1);

        // R4/R5 period and high time; R5 with duty equal to scale
        run_cfg("R4", 3, 4, 2, 1'b0);
        run_cfg("R5", 1, 5, 5, 1'b0);
        run_cfg("R5", 2, 3, 1, 1'b0);
        // R6 duty above scale
        run_cfg("R6", 2, 3, 7, 1'b0);
        // R7 zero duty
        run_cfg("R7", 2, 3, 0, 1'b0);
        // R8 zero prescale, zero scale
        run_cfg("R8", 0, 4, 2, 1'b0);
        run_cfg("R8", 3, 0, 2, 1'b0);
        // R9 inverted polarity, including idle level
        run_cfg("R9", 2, 4, 1, 1'b1);
        wr(BASE, 8'h01);
        @(negedge clk);
        check("R9", int'(pwm_out), 1);

        // R10 disable mid-period, then restart from period start
        setup(2, 4, 3, 1'b0);
        wr(BASE, 8'h02);
        cur_req = "R10";
        push(2, 4, 3, 1'b0, 1, 5);
        drain();
        wr(BASE, 8'h00);
        check("R10", int'(pwm_out), 0);
        @(negedge clk);
        check("R10", int'(pwm_out), 0);
        wr(BASE, 8'h02);
        push(2, 4, 3, 1'b0, 1, 0);
        drain();

        // R11 duty write while running shows immediately
        wr(BASE, 8'h00);
        setup(2, 4, 0, 1'b0);
        wr(BASE, 8'h02);
        repeat (3) @(negedge clk);
        check("R11", int'(pwm_out), 0);
        wr(BASE + 8'd4, 8'd5);
        check("R11", int'(pwm_out), 1);
        wr(BASE + 8'd4, 8'd0);
        check("R11", int'(pwm_out), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule